// File: doc/BRIEF.md
# Configurable Logic-Cell Output Register

This block is a single output cell of a programmable logic fabric. A sum-of-products term arrives on `d_in`, and a static configuration word decides how the cell treats it. The cell can latch the term in a D register or use it as a toggle command for a T register. It can also skip the register and pass the term straight through. The configuration also picks the clock and its edge, turns the per-block asynchronous clear/set terms on or off, and chooses where the output enable comes from.

The register can be clocked from one of four global clocks, and each global clock can be used on either edge. It can also be clocked from one of two control terms generated by block logic. A group of four further control terms supplies the output-enable choices. An active-low global tristate pin can override the enable when that override is switched on. The cell drives a value and an enable towards the pad. It returns two signals to the routing: `cell_fb`, taken before the buffer, and `pin_fb`, taken after it. When the buffer is off, `pin_fb` carries whatever the pad sees.

The configuration word is written through a small load port before operation and is then held.

Top module: `mcell_top`

## Requirements
- R1: The configuration register loads `cfg_data` on a rising `cfg_clk` edge when `cfg_we` is 1 and holds its value otherwise. The field layout from bit 0 upward is: mode[1:0], clock select[4:2], falling-edge flag[5], init enable[6], output-enable select[9:7], tristate-pin enable[10].
- R2: In mode 0 (D) the register takes `d_in` on each active edge of the selected clock.
- R3: In mode 1 (T) the register inverts on an active edge when `d_in` is 1 and keeps its value when `d_in` is 0.
- R4: In modes 2 and 3 (combinational) `out_val` and `cell_fb` equal `d_in` at all times, whatever the register holds.
- R5: Clock select values 0 to 3 pick `gclk[0]` to `gclk[3]`. Value 4 picks `ct[2]` and value 5 picks `ct[3]`. Values 6 and 7 give no clock. A clock that is not selected has no effect.
- R6: With the falling-edge flag set, a global clock acts on its falling edge and its rising edge has no effect. The two control-term clocks always act on their rising edge, whatever the flag says.
- R7: With init enable set, `ct[0]` clears the register and `ct[1]` sets it, both without waiting for a clock, and clear wins when both are high. With init enable clear, both terms are ignored.
- R8: While `por_n` is 0 the register and the configuration word are both zero. After reset the output enable therefore follows `ct[2]`.
- R9: Output-enable select values 0 to 3 follow `ct[2]` to `ct[5]`. Value 4 means always on, and values 5 to 7 mean always off.
- R10: When the tristate-pin enable is set and `gts_n` is 0, `out_en` is 0. When the tristate-pin enable is clear, `gts_n` has no effect.
- R11: `pin_fb` equals `out_val` while `out_en` is 1 and equals `pin_in` while `out_en` is 0. `cell_fb` always shows the cell value, whatever the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Clock for the configuration load port |
| por_n | input | 1 | Power-on reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_data | input | 11 | Configuration word to load |
| d_in | input | 1 | Sum-of-products data term |
| gclk | input | 4 | Global clocks |
| ct | input | 6 | Per-block control terms |
| gts_n | input | 1 | Global tristate pin, active low |
| pin_in | input | 1 | Level present on the pad |
| out_val | output | 1 | Value driven towards the pad |
| out_en | output | 1 | Output buffer enable |
| cell_fb | output | 1 | Feedback taken before the buffer |
| pin_fb | output | 1 | Feedback taken after the buffer |

## Verification
The properties are sampled on `cfg_clk`. They assume that every other input changes well away from its rising edge, so that an asynchronous clear or set, a combinational path and an enable choice have all settled by the time they are sampled. The stimulus therefore changes inputs only just after a falling `cfg_clk` edge.

Switching the clock selection can itself create a register edge. The bench avoids this in two ways. First, whenever the falling-edge flag is clear, every clock that could be selected is held low while a new configuration is loaded. Second, before selecting a global clock on its falling edge, the bench raises that clock so that its inverted level matches the level the register clock already has.

// File: rtl/mcell_pkg.sv
`timescale 1ns/1ps
package mcell_pkg;

  typedef enum logic [1:0] {
    MODE_D     = 2'd0,
    MODE_T     = 2'd1,
    MODE_COMB  = 2'd2,
    MODE_COMB2 = 2'd3
  } mode_e;

  // Field order matters: the load port writes this word as a flat vector.
  typedef struct packed {
    logic       gts_en;
    logic [2:0] oe_sel;
    logic       init_en;
    logic       fall;
    logic [2:0] clk_sel;
    mode_e      mode;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

endpackage

// File: rtl/mcell_clksel.sv
`timescale 1ns/1ps
module mcell_clksel #(
  parameter int GCLK_N = 4,
  parameter int SEL_W  = 3
) (
  input  logic [GCLK_N-1:0] gclk,
  input  logic [1:0]        ct_clk,
  input  logic [SEL_W-1:0]  sel,
  input  logic              fall,
  output logic              reg_clk
);

  localparam int SRC_N = 1 << SEL_W;

  logic [SRC_N-1:0] src;

  // Globals come first (with optional inversion), then two term clocks, then idle.
  generate
    for (genvar i = 0; i < SRC_N; i++) begin : g_src
      if (i < GCLK_N) begin : g_glob
        assign src[i] = gclk[i] ^ fall;
      end else if (i < GCLK_N + 2) begin : g_term
        assign src[i] = ct_clk[i-GCLK_N];
      end else begin : g_idle
        assign src[i] = 1'b0;
      end
    end
  endgenerate

  assign reg_clk = src[sel];

endmodule

// File: rtl/mcell_store.sv
`timescale 1ns/1ps
module mcell_store (
  input  logic reg_clk,
  input  logic por_n,
  input  logic clr,
  input  logic set,
  input  logic d,
  input  logic toggle,
  output logic q
);

  logic q_r;
  logic q_nx;

  always_comb begin
    if (toggle) q_nx = q_r ^ d;
    else        q_nx = d;
  end

  always_ff @(posedge reg_clk or negedge por_n or posedge clr or posedge set) begin
    if (!por_n)   q_r <= 1'b0;
    else if (clr) q_r <= 1'b0;
    else if (set) q_r <= 1'b1;
    else          q_r <= q_nx;
  end

  assign q = q_r;

endmodule

// File: rtl/mcell_oe.sv
`timescale 1ns/1ps
module mcell_oe #(
  parameter int SEL_W   = 3,
  parameter int N_OE_CT = 4
) (
  input  logic [N_OE_CT-1:0] oe_ct,
  input  logic [SEL_W-1:0]   sel,
  input  logic               gts_en,
  input  logic               gts_n,
  output logic               oe
);

  localparam int SRC_N = 1 << SEL_W;

  logic [SRC_N-1:0] src;
  logic             forced_off;

  generate
    for (genvar i = 0; i < SRC_N; i++) begin : g_src
      if (i < N_OE_CT) begin : g_term
        assign src[i] = oe_ct[i];
      end else if (i == N_OE_CT) begin : g_on
        assign src[i] = 1'b1;
      end else begin : g_off
        assign src[i] = 1'b0;
      end
    end
  endgenerate

  assign forced_off = gts_en & ~gts_n;
  assign oe         = src[sel] & ~forced_off;

endmodule

// File: rtl/mcell_top.sv
`timescale 1ns/1ps
module mcell_top
  import mcell_pkg::*;
#(
  parameter int GCLK_N = 4,
  parameter int CT_N   = 6
) (
  input  logic              cfg_clk,
  input  logic              por_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_data,
  input  logic              d_in,
  input  logic [GCLK_N-1:0] gclk,
  input  logic [CT_N-1:0]   ct,
  input  logic              gts_n,
  input  logic              pin_in,
  output logic              out_val,
  output logic              out_en,
  output logic              cell_fb,
  output logic              pin_fb
);

  localparam int SEL_W   = 3;
  localparam int N_OE_CT = CT_N - 2;

  cfg_t cfg_q;
  cfg_t cfg_nx;
  logic reg_clk;
  logic q_reg;
  logic clr;
  logic set;
  logic bypass;
  logic cell_val;

  // Configuration word: next-state and register kept apart.
  always_comb begin
    cfg_nx = cfg_q;
    if (cfg_we) cfg_nx = cfg_t'(cfg_data);
  end

  always_ff @(posedge cfg_clk or negedge por_n) begin
    if (!por_n) cfg_q <= '0;
    else        cfg_q <= cfg_nx;
  end

  mcell_clksel #(
    .GCLK_N (GCLK_N),
    .SEL_W  (SEL_W)
  ) u_clksel (
    .gclk    (gclk),
    .ct_clk  (ct[3:2]),
    .sel     (cfg_q.clk_sel),
    .fall    (cfg_q.fall),
    .reg_clk (reg_clk)
  );

  assign clr = cfg_q.init_en & ct[0];
  assign set = cfg_q.init_en & ct[1];

  mcell_store u_store (
    .reg_clk (reg_clk),
    .por_n   (por_n),
    .clr     (clr),
    .set     (set),
    .d       (d_in),
    .toggle  (cfg_q.mode == MODE_T),
    .q       (q_reg)
  );

  mcell_oe #(
    .SEL_W   (SEL_W),
    .N_OE_CT (N_OE_CT)
  ) u_oe (
    .oe_ct  (ct[CT_N-1:2]),
    .sel    (cfg_q.oe_sel),
    .gts_en (cfg_q.gts_en),
    .gts_n  (gts_n),
    .oe     (out_en)
  );

  assign bypass   = (cfg_q.mode == MODE_COMB) || (cfg_q.mode == MODE_COMB2);
  assign cell_val = bypass ? d_in : q_reg;
  assign out_val  = cell_val;
  assign cell_fb  = cell_val;
  assign pin_fb   = out_en ? cell_val : pin_in;

endmodule

// File: rtl/mcell_chk.sv
`timescale 1ns/1ps
module mcell_chk #(
  parameter int CFG_W = 11
) (
  input logic             cfg_clk,
  input logic             por_n,
  input logic             cfg_we,
  input logic [CFG_W-1:0] cfg_bits,
  input logic [1:0]       ct_init,
  input logic             gts_n,
  input logic             d_in,
  input logic             pin_in,
  input logic             out_en,
  input logic             pin_fb,
  input logic             cell_fb
);

  logic [1:0] f_mode;
  logic       f_init;
  logic [2:0] f_oe;
  logic       f_gts;
  logic       f_reg;

  assign f_mode = cfg_bits[1:0];
  assign f_init = cfg_bits[6];
  assign f_oe   = cfg_bits[9:7];
  assign f_gts  = cfg_bits[10];
  assign f_reg  = (f_mode == 2'd0) || (f_mode == 2'd1);

  p_cfg_hold_r1: assert property (@(posedge cfg_clk) disable iff (!por_n)
    !cfg_we |=> $stable(cfg_bits));

  p_comb_pass_r4: assert property (@(posedge cfg_clk) disable iff (!por_n)
    !f_reg |-> (cell_fb == d_in));

  p_clear_r7: assert property (@(posedge cfg_clk) disable iff (!por_n)
    (f_reg && f_init && ct_init[0]) |-> !cell_fb);

  p_set_r7: assert property (@(posedge cfg_clk) disable iff (!por_n)
    (f_reg && f_init && ct_init[1] && !ct_init[0]) |-> cell_fb);

  p_oe_off_r9: assert property (@(posedge cfg_clk) disable iff (!por_n)
    (f_oe >= 3'd5) |-> !out_en);

  p_gts_force_r10: assert property (@(posedge cfg_clk) disable iff (!por_n)
    (f_gts && !gts_n) |-> !out_en);

  p_pin_in_r11: assert property (@(posedge cfg_clk) disable iff (!por_n)
    !out_en |-> (pin_fb == pin_in));

endmodule

bind mcell_top mcell_chk #(.CFG_W(mcell_pkg::CFG_W)) u_chk (
  .cfg_clk  (cfg_clk),
  .por_n    (por_n),
  .cfg_we   (cfg_we),
  .cfg_bits (cfg_q),
  .ct_init  (ct[1:0]),
  .gts_n    (gts_n),
  .d_in     (d_in),
  .pin_in   (pin_in),
  .out_en   (out_en),
  .pin_fb   (pin_fb),
  .cell_fb  (cell_fb)
);

// File: tb/sim_mcell_top.sv
`timescale 1ns/1ps
module sim_mcell_top;

  logic        clk;
  logic        por_n;
  logic        cfg_we;
  logic [10:0] cfg_data;
  logic        d_in;
  logic [3:0]  gclk;
  logic [5:0]  ct;
  logic        gts_n;
  logic        pin_in;
  logic        out_val;
  logic        out_en;
  logic        cell_fb;
  logic        pin_fb;

  int n_chk = 0;
  int n_err = 0;

  mcell_top u0 (
    .cfg_clk (clk),
    .por_n   (por_n),
    .cfg_we  (cfg_we),
    .cfg_data(cfg_data),
    .d_in    (d_in),
    .gclk    (gclk),
    .ct      (ct),
    .gts_n   (gts_n),
    .pin_in  (pin_in),
    .out_val (out_val),
    .out_en  (out_en),
    .cell_fb (cell_fb),
    .pin_fb  (pin_fb)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [10:0] mk(input logic [1:0] mode, input logic [2:0] sel,
                                     input logic fall, input logic init,
                                     input logic [2:0] oe, input logic gts);
    return {gts, oe, init, fall, sel, mode};
  endfunction

  task automatic chk(input logic got, input logic exp, input string what);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %b expected %b", what, got, exp);
    end
  endtask

  task automatic load_cfg(input logic [10:0] v);
    @(negedge clk); cfg_data = v; cfg_we = 1'b1;
    @(negedge clk); cfg_we = 1'b0; #1;
  endtask

  task automatic pulse_g(input int idx);
    @(negedge clk); gclk[idx] = 1'b1; #1;
    @(negedge clk); gclk[idx] = 1'b0; #1;
  endtask

  task automatic pulse_ct(input int idx);
    @(negedge clk); ct[idx] = 1'b1; #1;
    @(negedge clk); ct[idx] = 1'b0; #1;
  endtask

  task automatic t_reset();
    @(negedge clk); pin_in = 1'b1; #1;
    chk(out_val, 1'b0, "R8 value after power-on");
    chk(out_en, 1'b0, "R8 enable follows ct2 (low) after reset");
    chk(pin_fb, 1'b1, "R11 pin feedback shows pad while disabled");
    @(negedge clk); ct[2] = 1'b1; #1;
    chk(out_en, 1'b1, "R8 reset config selects ct2 as enable");
    @(negedge clk); ct[2] = 1'b0; pin_in = 1'b0; #1;
  endtask

  task automatic t_dmode();
    load_cfg(mk(2'd0, 3'd0, 1'b0, 1'b0, 3'd4, 1'b0));
    @(negedge clk); d_in = 1'b1; gclk[0] = 1'b1; #1;
    chk(cell_fb, 1'b1, "R2 D captures 1 on rising gclk0");
    @(negedge clk); d_in = 1'b0; gclk[0] = 1'b0; #1;
    chk(cell_fb, 1'b1, "R6 falling gclk0 ignored with edge flag clear");
    pulse_g(1);
    chk(cell_fb, 1'b1, "R5 unselected gclk1 has no effect");
    pulse_g(0);
    chk(out_val, 1'b0, "R2 D captures 0 on next rising gclk0");
  endtask

  task automatic t_fall();
    @(negedge clk); gclk[2] = 1'b1; #1;
    load_cfg(mk(2'd0, 3'd2, 1'b1, 1'b0, 3'd4, 1'b0));
    @(negedge clk); d_in = 1'b1; gclk[2] = 1'b0; #1;
    chk(cell_fb, 1'b1, "R6 falling gclk2 captures when edge flag set");
    @(negedge clk); d_in = 1'b0; gclk[2] = 1'b1; #1;
    chk(cell_fb, 1'b1, "R6 rising gclk2 ignored when edge flag set");
    @(negedge clk); gclk[2] = 1'b0; #1;
    chk(cell_fb, 1'b0, "R6 second falling gclk2 captures 0");
  endtask

  task automatic t_tmode();
    load_cfg(mk(2'd1, 3'd1, 1'b0, 1'b0, 3'd4, 1'b0));
    @(negedge clk); d_in = 1'b1; #1;
    pulse_g(1);
    chk(cell_fb, 1'b1, "R3 T toggles 0->1");
    pulse_g(1);
    chk(cell_fb, 1'b0, "R3 T toggles 1->0");
    @(negedge clk); d_in = 1'b0; #1;
    pulse_g(1);
    chk(cell_fb, 1'b0, "R3 T holds 0 with d=0");
    @(negedge clk); d_in = 1'b1; #1;
    pulse_g(1);
    @(negedge clk); d_in = 1'b0; #1;
    pulse_g(1);
    chk(cell_fb, 1'b1, "R3 T holds 1 with d=0");
  endtask

  task automatic t_ctclk();
    load_cfg(mk(2'd0, 3'd4, 1'b1, 1'b0, 3'd4, 1'b0));
    pulse_ct(2);
    chk(cell_fb, 1'b0, "R5 ct2 clock captures 0");
    @(negedge clk); d_in = 1'b1; ct[2] = 1'b1; #1;
    chk(cell_fb, 1'b1, "R6 ct2 acts on rising edge despite edge flag");
    @(negedge clk); d_in = 1'b0; ct[2] = 1'b0; #1;
    chk(cell_fb, 1'b1, "R6 ct2 falling edge not used");
    load_cfg(mk(2'd0, 3'd5, 1'b0, 1'b0, 3'd4, 1'b0));
    pulse_ct(3);
    chk(cell_fb, 1'b0, "R5 ct3 clock captures 0");
    @(negedge clk); d_in = 1'b1; #1;
    pulse_g(0);
    chk(cell_fb, 1'b0, "R5 gclk0 ignored while ct3 selected");
    @(negedge clk); d_in = 1'b0; #1;
  endtask

  task automatic t_init();
    load_cfg(mk(2'd0, 3'd0, 1'b0, 1'b1, 3'd4, 1'b0));
    @(negedge clk); ct[1] = 1'b1; #1;
    chk(cell_fb, 1'b1, "R7 ct1 sets without clock");
    @(negedge clk); ct[1] = 1'b0; #1;
    chk(cell_fb, 1'b1, "R7 set value held after ct1 drops");
    @(negedge clk); ct[0] = 1'b1; #1;
    chk(cell_fb, 1'b0, "R7 ct0 clears without clock");
    @(negedge clk); ct[1] = 1'b1; #1;
    chk(cell_fb, 1'b0, "R7 clear wins over set");
    @(negedge clk); d_in = 1'b1; gclk[0] = 1'b1; #1;
    chk(cell_fb, 1'b0, "R7 clock blocked while clear held");
    @(negedge clk); gclk[0] = 1'b0; ct[1] = 1'b0; #1;
    @(negedge clk); ct[0] = 1'b0; d_in = 1'b0; #1;
    load_cfg(mk(2'd0, 3'd0, 1'b0, 1'b0, 3'd4, 1'b0));
    @(negedge clk); ct[1] = 1'b1; #1;
    chk(cell_fb, 1'b0, "R7 ct1 ignored with init disabled");
    @(negedge clk); ct[1] = 1'b0; #1;
  endtask

  task automatic t_comb();
    load_cfg(mk(2'd2, 3'd0, 1'b0, 1'b0, 3'd4, 1'b0));
    @(negedge clk); d_in = 1'b1; #1;
    chk(out_val, 1'b1, "R4 combinational passes 1");
    @(negedge clk); d_in = 1'b0; #1;
    chk(cell_fb, 1'b0, "R4 combinational passes 0");
    load_cfg(mk(2'd3, 3'd0, 1'b0, 1'b1, 3'd4, 1'b0));
    @(negedge clk); ct[1] = 1'b1; #1;
    chk(out_val, 1'b0, "R4 register set hidden in combinational mode");
    @(negedge clk); ct[1] = 1'b0; #1;
  endtask

  task automatic t_oe();
    for (int s = 0; s < 4; s++) begin
      load_cfg(mk(2'd0, 3'd0, 1'b0, 1'b0, 3'(s), 1'b0));
      @(negedge clk); ct[5:2] = 4'(1 << s); #1;
      chk(out_en, 1'b1, $sformatf("R9 enable follows selected term sel=%0d", s));
      @(negedge clk); ct[5:2] = ~4'(1 << s); #1;
      chk(out_en, 1'b0, $sformatf("R9 other terms ignored sel=%0d", s));
      @(negedge clk); ct[5:2] = 4'b0; #1;
    end
    load_cfg(mk(2'd0, 3'd0, 1'b0, 1'b0, 3'd4, 1'b0));
    chk(out_en, 1'b1, "R9 select 4 always on");
    load_cfg(mk(2'd0, 3'd0, 1'b0, 1'b0, 3'd5, 1'b0));
    @(negedge clk); ct[5:2] = 4'hF; #1;
    chk(out_en, 1'b0, "R9 select 5 always off");
    load_cfg(mk(2'd0, 3'd0, 1'b0, 1'b0, 3'd7, 1'b0));
    chk(out_en, 1'b0, "R9 select 7 always off");
    @(negedge clk); ct[5:2] = 4'b0; #1;
  endtask

  task automatic t_gts();
    load_cfg(mk(2'd0, 3'd0, 1'b0, 1'b0, 3'd4, 1'b1));
    @(negedge clk); gts_n = 1'b0; #1;
    chk(out_en, 1'b0, "R10 tristate pin forces enable off");
    @(negedge clk); gts_n = 1'b1; #1;
    chk(out_en, 1'b1, "R10 enable restored when pin released");
    load_cfg(mk(2'd0, 3'd0, 1'b0, 1'b0, 3'd4, 1'b0));
    @(negedge clk); gts_n = 1'b0; #1;
    chk(out_en, 1'b1, "R10 tristate pin ignored when not enabled");
    @(negedge clk); gts_n = 1'b1; #1;
  endtask

  task automatic t_pinfb();
    @(negedge clk); d_in = 1'b1; #1;
    pulse_g(0);
    @(negedge clk); d_in = 1'b0; pin_in = 1'b0; #1;
    chk(pin_fb, 1'b1, "R11 pin feedback shows driven value");
    load_cfg(mk(2'd0, 3'd0, 1'b0, 1'b0, 3'd5, 1'b0));
    chk(pin_fb, 1'b0, "R11 pin feedback shows pad 0 when disabled");
    @(negedge clk); pin_in = 1'b1; #1;
    chk(pin_fb, 1'b1, "R11 pin feedback shows pad 1 when disabled");
    chk(cell_fb, 1'b1, "R11 cell feedback unaffected by enable");
    @(negedge clk); pin_in = 1'b0; #1;
  endtask

  task automatic t_cfg_hold();
    load_cfg(mk(2'd0, 3'd0, 1'b0, 1'b0, 3'd4, 1'b0));
    @(negedge clk); cfg_data = mk(2'd0, 3'd0, 1'b0, 1'b0, 3'd5, 1'b0); cfg_we = 1'b0;
    @(negedge clk); @(negedge clk); #1;
    chk(out_en, 1'b1, "R1 data ignored without write strobe");
    @(negedge clk); cfg_we = 1'b1;
    @(negedge clk); cfg_we = 1'b0; #1;
    chk(out_en, 1'b0, "R1 data taken with write strobe");
  endtask

  task automatic t_por_again();
    load_cfg(mk(2'd0, 3'd0, 1'b0, 1'b0, 3'd4, 1'b0));
    @(negedge clk); d_in = 1'b1; #1;
    pulse_g(0);
    @(negedge clk); d_in = 1'b0; por_n = 1'b0; #1;
    chk(out_val, 1'b0, "R8 reset clears register");
    chk(out_en, 1'b0, "R8 reset clears configuration");
    @(negedge clk); por_n = 1'b1; #1;
  endtask

  initial begin
    por_n = 1'b0; cfg_we = 1'b0; cfg_data = '0; d_in = 1'b0;
    gclk = '0; ct = '0; gts_n = 1'b1; pin_in = 1'b0;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    t_reset();
    t_dmode();
    t_fall();
    t_tmode();
    t_ctclk();
    t_init();
    t_comb();
    t_oe();
    t_gts();
    t_pinfb();
    t_cfg_hold();
    t_por_again();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #500000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired, all requirements: got running expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule